// File: doc/BRIEF.md
# Configurable Processor Bus Slave Adapter

This block is the slave-side front end that lets one set of internal memory-mapped registers sit on the bus of many different host processors. A static configuration chooses the control style, multiplexed or separate addressing, and an 8- or 16-bit data path. The same four control pins are given different meanings depending on the chosen style. Across the styles they cover separate read and write strobes, a read/write level qualified by an enable or a data strobe, split low and high write strobes, lower and upper data strobes, and a transfer-size select.

The adapter finds the byte address. In multiplexed mode it captures the address from the shared data port while the address-latch-enable pin is high; otherwise it uses the separate address inputs. From the pins it builds one internal read strobe, one internal write strobe and a low and a high byte-lane enable. A small register file sits behind an address decoder. Register data leaves through the bidirectional port, which is driven only while a read to a selected address is in progress and is high-impedance at all other times.

Top module: `mcu_bus_adapter`

## Requirements
- R1: While rst_n is low and afterwards until the first selected read, `ad` is high-impedance, and every register reads back as zero after reset.
- R2: With multiplexed addressing, the address is taken from `ad` on clock edges where `pin_sp1` (address-latch enable) is high and is held while it is low, so data on `ad` during the data phase does not move it. With separate addressing, `addr_in` is used directly. Style 6 always uses separate addressing.
- R3: A read to a selected address is answered at the first clock edge at which the read strobe is sampled active. In 16-bit mode the whole word is driven on `ad[15:0]`. In 8-bit mode, `ad[7:0]` carries the byte picked by address bit 0 (0 = low byte) and `ad[15:8]` stays released.
- R4: `ad` is released one edge after the read strobe is removed. It is never driven after a write or for an address outside the window BASE to BASE+2*NWORDS-1 (0x40..0x4F by default). A write outside the window changes no register.
- R5: Style 0 (8-bit only): `pin_rd` is read (low), `pin_wr` is write (low), and `pin_sp0` is a second read strobe (low) for code fetches.
- R6: Style 1: `pin_wr` is R/W (1 = read) and `pin_rd` is an active-high enable. A transfer happens while the enable is high. In 16-bit mode, address bit 0 = 0 enables the low lane and `pin_sp0` low enables the high lane.
- R7: Style 2: `pin_rd` and `pin_wr` are active-low read and write strobes. In 16-bit mode the lanes follow the rule of R6 (address bit 0 for the low lane, `pin_sp0` low for the high lane).
- R8: Style 3 (always 16-bit): `pin_rd` is read (low), `pin_wr` low writes the low byte and `pin_sp0` low writes the high byte. Reads drive both lanes.
- R9: Style 4 (always 16-bit): `pin_wr` is R/W, `pin_rd` is the lower data strobe and `pin_sp0` the upper data strobe (both low-active). Each strobe enables its own lane.
- R10: Style 5: `pin_wr` is R/W and `pin_rd` is an active-low data strobe. `pin_sp0` = 1 makes a single-byte transfer on the lane chosen by address bit 0, and `pin_sp0` = 0 makes a word transfer.
- R11: Style 6: `pin_wr` is R/W and `pin_rd` is an active-low data strobe. `pin_sp1` low enables the low lane and `pin_sp0` low enables the high lane.
- R12: In 8-bit mode a write takes `ad[7:0]` into the lane chosen by address bit 0, whatever the lane pins say.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-synchronous clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_style | input | 3 | Control style code 0..6 |
| cfg_mux | input | 1 | 1 = address and data share `ad` |
| cfg_wide | input | 1 | 1 = 16-bit data path (styles 1, 2, 5, 6) |
| pin_rd | input | 1 | Read strobe / enable / data strobe / lower data strobe |
| pin_wr | input | 1 | Write strobe / R/W / low-byte write |
| pin_sp0 | input | 1 | High-byte enable / code read / high-byte write / upper strobe / size |
| pin_sp1 | input | 1 | Address-latch enable or low-byte enable |
| addr_in | input | AW | Byte address for separate addressing |
| ad | inout | 16 | Shared address/data port |

## Verification
Read data is due one register stage after the strobe: the bench applies the strobe at a falling edge and expects the word on `ad` a quarter period after the next rising edge. It expects release at the same point one cycle later. Each read therefore pushes two expectations, the data and then all-high-impedance, and a monitor pops one entry a quarter period after every rising edge, so every pop lines up with the cycle in which the result is due. A write changes no port, so its effect is checked through a later read of the same address.

// File: rtl/mba_pkg.sv
// Shared types for the processor bus adapter.
// Assumes: style codes are fixed by static configuration between transfers.
package mba_pkg;

    typedef enum logic [2:0] {
        ST_SEP_PSEN  = 3'd0,
        ST_RW_E      = 3'd1,
        ST_SEP_BHE   = 3'd2,
        ST_SPLIT_WR  = 3'd3,
        ST_RW_LUDS   = 3'd4,
        ST_RW_DS_SIZ = 3'd5,
        ST_RW_DS_BLE = 3'd6,
        ST_NONE      = 3'd7
    } bus_style_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic lo;
        logic hi;
    } bus_req_t;

    // Effective data width: some styles fix it regardless of cfg_wide
    function automatic logic style_wide(bus_style_e s, logic w);
        case (s)
            ST_SEP_PSEN:             return 1'b0;
            ST_SPLIT_WR, ST_RW_LUDS: return 1'b1;
            default:                 return w;
        endcase
    endfunction

    // Effective addressing: style 6 uses pin_sp1 as a lane enable, so no latch
    function automatic logic style_mux(bus_style_e s, logic m);
        return (s == ST_RW_DS_BLE) ? 1'b0 : m;
    endfunction

endpackage

// File: rtl/mba_pin_decode.sv
// Maps the four shared control pins onto read/write strobes and byte lanes.
// Assumes: pins are synchronous to clk; a0 is the effective address bit 0.
module mba_pin_decode
    import mba_pkg::*;
(
    input  bus_style_e style,
    input  logic       wide,
    input  logic       rd_pin,
    input  logic       wr_pin,
    input  logic       sp0_pin,
    input  logic       sp1_pin,
    input  logic       a0,
    output bus_req_t   req
);

    logic lo_w;
    logic hi_w;
    logic strb;

    // Decode the pins per style, then override lanes for the 8-bit path
    always_comb begin
        req  = '0;
        lo_w = 1'b0;
        hi_w = 1'b0;
        strb = 1'b0;
        case (style)
            ST_SEP_PSEN: begin
                req.rd = ~rd_pin | ~sp0_pin;
                req.wr = ~wr_pin;
            end
            ST_RW_E: begin
                req.rd = rd_pin & wr_pin;
                req.wr = rd_pin & ~wr_pin;
                lo_w   = ~a0;
                hi_w   = ~sp0_pin;
            end
            ST_SEP_BHE: begin
                req.rd = ~rd_pin;
                req.wr = ~wr_pin;
                lo_w   = ~a0;
                hi_w   = ~sp0_pin;
            end
            ST_SPLIT_WR: begin
                req.rd = ~rd_pin;
                req.wr = ~wr_pin | ~sp0_pin;
                lo_w   = ~wr_pin;
                hi_w   = ~sp0_pin;
            end
            ST_RW_LUDS: begin
                strb   = ~rd_pin | ~sp0_pin;
                req.rd = strb & wr_pin;
                req.wr = strb & ~wr_pin;
                lo_w   = ~rd_pin;
                hi_w   = ~sp0_pin;
            end
            ST_RW_DS_SIZ: begin
                req.rd = ~rd_pin & wr_pin;
                req.wr = ~rd_pin & ~wr_pin;
                lo_w   = sp0_pin ? ~a0 : 1'b1;
                hi_w   = sp0_pin ?  a0 : 1'b1;
            end
            ST_RW_DS_BLE: begin
                req.rd = ~rd_pin & wr_pin;
                req.wr = ~rd_pin & ~wr_pin;
                lo_w   = ~sp1_pin;
                hi_w   = ~sp0_pin;
            end
            default: begin
                req.rd = 1'b0;
                req.wr = 1'b0;
            end
        endcase
        if (wide) begin
            req.lo = lo_w;
            req.hi = hi_w;
        end else begin
            req.lo = ~a0;
            req.hi = a0;
        end
    end

endmodule

// File: rtl/mba_addr_latch.sv
// Address capture for multiplexed buses; pass-through for separate address.
// Assumes: the latch follows the shared port on edges where ale is high.
module mba_addr_latch #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mux_en,
    input  logic          ale,
    input  logic [AW-1:0] ad_addr,
    input  logic [AW-1:0] direct,
    output logic [AW-1:0] addr_eff,
    output logic [AW-1:0] addr_hold
);

    // Capture the shared port while ale is high, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_hold <= '0;
        else if (mux_en && ale)
            addr_hold <= ad_addr;
    end

    // Select the live port during ale, the held value after, or direct pins
    always_comb begin
        if (!mux_en)
            addr_eff = direct;
        else if (ale)
            addr_eff = ad_addr;
        else
            addr_eff = addr_hold;
    end

endmodule

// File: rtl/mba_regfile.sv
// Register file behind a window decoder, with byte-lane writes and a
// width-steered read word.
// Assumes: NWORDS is a power of two, at least 2; BASE is aligned to the window.
module mba_regfile
    import mba_pkg::*;
#(
    parameter int          AW     = 16,
    parameter int          NWORDS = 8,
    parameter logic [AW-1:0] BASE = 16'h0040
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wide,
    input  bus_req_t      req,
    input  logic [15:0]   wdata,
    output logic          hit,
    output logic [15:0]   rdata
);

    localparam int WB = $clog2(NWORDS);
    localparam int SB = WB + 1;

    logic [WB-1:0] idx;
    logic [7:0]    lo_d;
    logic [7:0]    hi_d;
    logic [15:0]   words [NWORDS];
    logic [15:0]   word;

    assign idx  = addr[WB:1];
    assign hit  = (addr[AW-1:SB] == BASE[AW-1:SB]);
    assign lo_d = wdata[7:0];
    assign hi_d = wide ? wdata[15:8] : wdata[7:0];

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        logic [15:0] word_q;

        // Update the enabled byte lanes of this word on a selected write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (hit && req.wr && idx == WB'(g)) begin
                if (req.lo) word_q[7:0]  <= lo_d;
                if (req.hi) word_q[15:8] <= hi_d;
            end
        end

        assign words[g] = word_q;
    end

    assign word = words[idx];

    // Steer the addressed byte onto the low lane for the 8-bit path
    always_comb begin
        if (wide)
            rdata = word;
        else
            rdata = {8'h00, addr[0] ? word[15:8] : word[7:0]};
    end

endmodule

// File: rtl/mcu_bus_adapter.sv
// Top of the configurable processor bus slave adapter.
// Assumes: configuration inputs change only while the bus is idle; all
// control pins are sampled on clk; ad is released by the host during reads.
module mcu_bus_adapter
    import mba_pkg::*;
#(
    parameter int            AW     = 16,
    parameter int            NWORDS = 8,
    parameter logic [AW-1:0] BASE   = 16'h0040
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    cfg_style,
    input  logic          cfg_mux,
    input  logic          cfg_wide,
    input  logic          pin_rd,
    input  logic          pin_wr,
    input  logic          pin_sp0,
    input  logic          pin_sp1,
    input  logic [AW-1:0] addr_in,
    inout  wire  [15:0]   ad
);

    localparam int LANES = 2;

    bus_style_e    style;
    logic          wide_eff;
    logic          mux_eff;
    logic [AW-1:0] bus_addr;
    logic [AW-1:0] addr_hold;
    bus_req_t      req;
    logic          strobe_rd;
    logic          strobe_wr;
    logic          bus_hit;
    logic [15:0]   rd_bus;
    logic [LANES-1:0] ad_oe;
    logic [15:0]   dout_q;

    assign style     = bus_style_e'(cfg_style);
    assign wide_eff  = style_wide(style, cfg_wide);
    assign mux_eff   = style_mux(style, cfg_mux);
    assign strobe_rd = req.rd;
    assign strobe_wr = req.wr;

    mba_addr_latch #(.AW(AW)) i_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .mux_en    (mux_eff),
        .ale       (pin_sp1),
        .ad_addr   (ad[AW-1:0]),
        .direct    (addr_in),
        .addr_eff  (bus_addr),
        .addr_hold (addr_hold)
    );

    mba_pin_decode i_decode (
        .style   (style),
        .wide    (wide_eff),
        .rd_pin  (pin_rd),
        .wr_pin  (pin_wr),
        .sp0_pin (pin_sp0),
        .sp1_pin (pin_sp1),
        .a0      (bus_addr[0]),
        .req     (req)
    );

    mba_regfile #(.AW(AW), .NWORDS(NWORDS), .BASE(BASE)) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .wide  (wide_eff),
        .req   (req),
        .wdata (ad),
        .hit   (bus_hit),
        .rdata (rd_bus)
    );

    // Register the read word and the lane drive enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ad_oe  <= '0;
            dout_q <= '0;
        end else begin
            ad_oe  <= (bus_hit && strobe_rd) ? (wide_eff ? 2'b11 : 2'b01) : 2'b00;
            dout_q <= rd_bus;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign ad[l*8 +: 8] = ad_oe[l] ? dout_q[l*8 +: 8] : 8'hzz;
    end

endmodule

// File: rtl/mba_checker.sv
// Temporal checks on the bus adapter, attached to every instance by bind.
// Assumes: configuration is stable across a transfer.
module mba_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    cfg_style,
    input logic          cfg_wide,
    input logic          pin_sp1,
    input logic [1:0]    ad_oe,
    input logic          bus_hit,
    input logic          strobe_rd,
    input logic          strobe_wr,
    input logic [AW-1:0] addr_hold
);

    logic narrow;
    logic forced_wide;

    assign narrow      = (cfg_style == 3'd0) ||
                         (!cfg_wide && cfg_style != 3'd3 && cfg_style != 3'd4);
    assign forced_wide = (cfg_style == 3'd3) || (cfg_style == 3'd4);

    AST_OE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe != 2'b00) |-> $past(bus_hit && strobe_rd)); // R4

    AST_NO_DRIVE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(strobe_wr && !strobe_rd) |-> (ad_oe == 2'b00)); // R4

    AST_UPPER_LANE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        narrow |-> !ad_oe[1]); // R3

    AST_FORCED_WIDE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (forced_wide && ad_oe != 2'b00) |-> (ad_oe == 2'b11)); // R8

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_sp1 && $past(!pin_sp1)) |-> $stable(addr_hold)); // R2

endmodule

bind mcu_bus_adapter mba_checker #(.AW(AW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_style (cfg_style),
    .cfg_wide  (cfg_wide),
    .pin_sp1   (pin_sp1),
    .ad_oe     (ad_oe),
    .bus_hit   (bus_hit),
    .strobe_rd (strobe_rd),
    .strobe_wr (strobe_wr),
    .addr_hold (addr_hold)
);

// File: tb/test_mcu_bus_adapter.sv
// Scoreboard bench: bus tasks push expected port values, a monitor pops one
// per cycle a quarter period after each rising edge and compares.
module test_mcu_bus_adapter;

    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  style_r = 3'd0;
    logic        mux_r = 1'b0;
    logic        wide_r = 1'b0;
    logic        pin_rd = 1'b1;
    logic        pin_wr = 1'b1;
    logic        pin_sp0 = 1'b1;
    logic        pin_sp1 = 1'b0;
    logic [15:0] addr_in = '0;
    logic [15:0] ad_drv = '0;
    logic        ad_en = 1'b0;
    wire  [15:0] ad;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [15:0] mem_m [8];
    logic [15:0] exp_q [$];
    string       tag_q [$];

    assign ad = ad_en ? ad_drv : 16'hzzzz;

    always #(CLK_PER/2) clk = ~clk;

    mcu_bus_adapter i_mcu_bus_adapter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_style (style_r),
        .cfg_mux   (mux_r),
        .cfg_wide  (wide_r),
        .pin_rd    (pin_rd),
        .pin_wr    (pin_wr),
        .pin_sp0   (pin_sp0),
        .pin_sp1   (pin_sp1),
        .addr_in   (addr_in),
        .ad        (ad)
    );

    function automatic bit b_wide();
        if (style_r == 3'd0) return 1'b0;
        if (style_r == 3'd3 || style_r == 3'd4) return 1'b1;
        return wide_r;
    endfunction

    function automatic bit b_mux();
        return (style_r == 3'd6) ? 1'b0 : mux_r;
    endfunction

    function automatic bit b_hit(logic [15:0] a);
        return a[15:4] == 12'h004;
    endfunction

    task automatic pins_idle();
        pin_rd  = (style_r == 3'd1) ? 1'b0 : 1'b1;
        pin_wr  = 1'b1;
        pin_sp0 = (style_r == 3'd5) ? 1'b0 : 1'b1;
        pin_sp1 = (style_r == 3'd6) ? 1'b1 : 1'b0;
    endtask

    task automatic pins_strobe(bit w, bit lo, bit hi, bit psen);
        case (style_r)
            3'd0: begin
                if (w) pin_wr = 1'b0;
                else if (psen) pin_sp0 = 1'b0;
                else pin_rd = 1'b0;
            end
            3'd1: begin pin_rd = 1'b1; pin_wr = ~w; pin_sp0 = ~hi; end
            3'd2: begin
                if (w) pin_wr = 1'b0; else pin_rd = 1'b0;
                pin_sp0 = ~hi;
            end
            3'd3: begin
                if (w) begin pin_wr = ~lo; pin_sp0 = ~hi; end
                else pin_rd = 1'b0;
            end
            3'd4: begin pin_wr = ~w; pin_rd = ~lo; pin_sp0 = ~hi; end
            3'd5: begin pin_wr = ~w; pin_rd = 1'b0; pin_sp0 = lo ^ hi; end
            3'd6: begin pin_wr = ~w; pin_rd = 1'b0; pin_sp0 = ~hi; pin_sp1 = ~lo; end
            default: ;
        endcase
    endtask

    task automatic set_cfg(logic [2:0] s, logic m, logic w);
        @(negedge clk);
        style_r = s;
        mux_r   = m;
        wide_r  = w;
        pins_idle();
    endtask

    task automatic bus_write(logic [15:0] a, logic [15:0] d, bit lo, bit hi);
        if (b_mux()) begin
            @(negedge clk);
            ad_drv = a; ad_en = 1'b1; pin_sp1 = 1'b1;
        end
        @(negedge clk);
        if (b_mux()) pin_sp1 = 1'b0; else addr_in = a;
        ad_drv = d; ad_en = 1'b1;
        pins_strobe(1'b1, lo, hi, 1'b0);
        @(negedge clk);
        pins_idle();
        ad_en = 1'b0;
        if (b_hit(a)) begin
            if (b_wide()) begin
                if (lo) mem_m[a[3:1]][7:0]  = d[7:0];
                if (hi) mem_m[a[3:1]][15:8] = d[15:8];
            end else if (a[0]) begin
                mem_m[a[3:1]][15:8] = d[7:0];
            end else begin
                mem_m[a[3:1]][7:0] = d[7:0];
            end
        end
    endtask

    task automatic bus_read(logic [15:0] a, string tag, bit psen = 1'b0);
        logic [15:0] e;
        logic [15:0] w;
        if (b_mux()) begin
            @(negedge clk);
            ad_drv = a; ad_en = 1'b1; pin_sp1 = 1'b1;
        end
        @(negedge clk);
        if (b_mux()) pin_sp1 = 1'b0; else addr_in = a;
        ad_en = 1'b0;
        pins_strobe(1'b0, 1'b1, 1'b1, psen);
        w = mem_m[a[3:1]];
        if (!b_hit(a)) e = 16'hzzzz;
        else if (b_wide()) e = w;
        else e = {8'hzz, a[0] ? w[15:8] : w[7:0]};
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        pins_idle();
        exp_q.push_back(16'hzzzz);
        tag_q.push_back("R4 release");
    endtask

    // Monitor: compare the port against the oldest expectation
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PER/4);
            if (exp_q.size() > 0) begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if (ad !== e) begin
                    n_fails++;
                    $display("FAIL %s: ad=%h expected %h", t, ad, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: done=0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) mem_m[i] = '0;
        pins_idle();
        repeat (3) @(negedge clk);
        n_checks++;
        if (ad !== 16'hzzzz) begin // R1
            n_fails++;
            $display("FAIL R1 reset: ad=%h expected zzzz", ad);
        end
        rst_n = 1'b1;

        // Style 0, multiplexed, 8-bit
        set_cfg(3'd0, 1'b1, 1'b0);
        bus_read(16'h0040, "R1 reset value");
        bus_write(16'h0041, 16'h00A5, 1'b0, 1'b1);
        bus_write(16'h0040, 16'h003C, 1'b1, 1'b0);
        bus_read(16'h0040, "R5 rd strobe");
        bus_read(16'h0041, "R5 code read strobe", 1'b1);
        bus_read(16'h0080, "R4 unselected");

        // Style 1, multiplexed, 16-bit
        set_cfg(3'd1, 1'b1, 1'b1);
        bus_write(16'h0042, 16'h1234, 1'b1, 1'b1);
        bus_write(16'h0043, 16'hAB00, 1'b0, 1'b1);
        bus_read(16'h0042, "R6 R/W with enable");

        // Style 1, separate address, 8-bit
        set_cfg(3'd1, 1'b0, 1'b0);
        bus_write(16'h0044, 16'h0077, 1'b1, 1'b0);
        bus_read(16'h0044, "R12 low byte");
        bus_read(16'h0045, "R12 high byte untouched");
        bus_read(16'h0043, "R3 narrow steer");

        // Style 2, multiplexed, 16-bit
        set_cfg(3'd2, 1'b1, 1'b1);
        bus_write(16'h0046, 16'hBEEF, 1'b1, 1'b1);
        bus_write(16'h0046, 16'h0011, 1'b1, 1'b0);
        bus_read(16'h0046, "R7 low lane only");
        bus_write(16'h0047, 16'h5500, 1'b0, 1'b1);
        bus_read(16'h0046, "R2 latched address across data phase");

        // Style 3, 8-bit requested but forced wide
        set_cfg(3'd3, 1'b1, 1'b0);
        bus_write(16'h0048, 16'hC3FF, 1'b0, 1'b1);
        bus_write(16'h0048, 16'hFFD4, 1'b1, 1'b0);
        bus_read(16'h0048, "R8 split write strobes");

        // Style 4, separate address, forced wide
        set_cfg(3'd4, 1'b0, 1'b0);
        bus_write(16'h004A, 16'h600D, 1'b1, 1'b1);
        bus_write(16'h004A, 16'h9900, 1'b0, 1'b1);
        bus_read(16'h004A, "R9 upper strobe only");

        // Style 5, separate address, 16-bit
        set_cfg(3'd5, 1'b0, 1'b1);
        bus_write(16'h004C, 16'h2468, 1'b1, 1'b1);
        bus_write(16'h004D, 16'h1300, 1'b0, 1'b1);
        bus_write(16'h004C, 16'h00FF, 1'b1, 1'b0);
        bus_read(16'h004C, "R10 size select");

        // Style 6, multiplexing requested but ignored
        set_cfg(3'd6, 1'b1, 1'b1);
        bus_write(16'h004E, 16'h0042, 1'b1, 1'b0);
        bus_write(16'h004E, 16'h8100, 1'b0, 1'b1);
        bus_read(16'h004E, "R11 lane strobes");

        // Unselected write must not alter any register
        set_cfg(3'd2, 1'b0, 1'b1);
        bus_write(16'h0090, 16'hDEAD, 1'b1, 1'b1);
        bus_write(16'h0002, 16'hF00D, 1'b1, 1'b1);
        for (int i = 0; i < 8; i++)
            bus_read(16'h0040 + 16'(2 * i), "R4 window write isolation");
        bus_read(16'h0020, "R4 unselected");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule